// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit builds a 32-bit memory address for a load or store from up to three terms. The first is a base register value. The second is an index register value shifted left by a scale code. The third is a signed displacement that is one, two or four bytes wide. Each term can be switched off, so one datapath covers several addressing modes:

- register-indirect
- base plus displacement
- base plus index, with or without a displacement
- base plus scaled index

The unit also checks the operand request. It raises a fault flag when the stack pointer is named as the index register, or when both the source and the destination of a move are in memory.

A request is presented on the input pins together with a valid strobe. The unit has a single register stage, so the address, the fault flag and the output valid all appear one clock later. While no request is presented, the address output keeps its last value. The address is computed modulo 2^32.

Top module: `scaled_ea_unit`

## Requirements
- R1: One cycle after a legal request, `ea_addr` equals base term + scaled index term + displacement term, modulo 2^32.
- R2: The scale code multiplies the index by a power of two before the addition: 0 gives x1, 1 gives x2, 2 gives x4, 3 gives x8.
- R3: The displacement size code selects the displacement term:
  - 0: the term is zero, whatever `disp_raw` holds.
  - 1: bits 7:0 of `disp_raw`, sign-extended.
  - 2: bits 15:0 of `disp_raw`, sign-extended.
  - 3: all 32 bits of `disp_raw`.
- R4: When `idx_en` is 0, the index term is zero, whatever `idx_val` and `scale_code` hold.
- R5: When `base_en` is 0, the base term is zero, whatever `base_val` holds.
- R6: When `idx_en` is 1 and `idx_sel` equals 6 (the stack pointer), `ea_fault` is 1 one cycle later. Other index numbers raise no fault. `ea_addr` is unspecified in that cycle.
- R7: When `src_mem` and `dst_mem` are both 1, `ea_fault` is 1 one cycle later. A request with only one memory operand raises no fault.
- R8: `ea_valid` equals `req_valid` delayed by one cycle. In a cycle after no request, `ea_fault` is 0 and `ea_addr` keeps its previous value.
- R9: While reset (`rst_n` = 0) is held and after it is released, `ea_valid`, `ea_fault` and `ea_addr` are all 0 until the first request.
- R10: Sums that pass 2^32 wrap around; no carry beyond bit 31 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| base_en | input | 1 | Base register term is present |
| base_val | input | 32 | Base register value |
| idx_en | input | 1 | Index register term is present |
| idx_sel | input | 3 | Index register number (6 = stack pointer) |
| idx_val | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp_raw | input | 32 | Displacement bits |
| disp_size | input | 2 | Displacement width code (0 none, 1 byte, 2 half, 3 word) |
| src_mem | input | 1 | Source operand is in memory |
| dst_mem | input | 1 | Destination operand is in memory |
| ea_valid | output | 1 | Registered result is valid |
| ea_addr | output | 32 | Registered effective address |
| ea_fault | output | 1 | Registered illegal-encoding flag |

## Verification
Every result of this block is due exactly one rising edge after its request: the address, the fault flag and the valid bit. The bench drives each request on a falling edge. On the following falling edge, after the single register has captured the request, it compares all three outputs against the expectation a reference model formed from that same request. Idle cycles are compared in the same slot, which covers the hold of the address. When a fault is expected, the address compare is skipped.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_BYTE = 2'd1,
        DSZ_HALF = 2'd2,
        DSZ_WORD = 2'd3
    } disp_size_e;

    typedef struct packed {
        logic              vld;
        logic              flt;
        logic [ADDR_W-1:0] addr;
    } ea_state_t;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] raw,
    input  logic [1:0]    size,
    output logic [AW-1:0] ext
);
    always_comb begin
        unique case (disp_size_e'(size))
            DSZ_NONE: ext = '0;
            DSZ_BYTE: ext = {{(AW-8){raw[7]}}, raw[7:0]};
            DSZ_HALF: ext = {{(AW-16){raw[15]}}, raw[15:0]};
            default:  ext = raw;
        endcase
    end
endmodule

// File: rtl/ea_idx_scaler.sv
module ea_idx_scaler #(
    parameter int AW        = 32,
    parameter int MAX_SHIFT = 3,
    localparam int NSH      = MAX_SHIFT + 1,
    localparam int SC_W     = $clog2(NSH)
) (
    input  logic            en,
    input  logic [SC_W-1:0] code,
    input  logic [AW-1:0]   val,
    output logic [AW-1:0]   scaled
);
    logic [AW-1:0] cand [NSH];

    for (genvar s = 0; s < NSH; s++) begin : g_shift
        assign cand[s] = val << s;
    end

    assign scaled = en ? cand[code] : '0;
endmodule

// File: rtl/scaled_ea_unit.sv
module scaled_ea_unit
    import ea_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int RSEL_W    = 3,
    parameter int SP_NUM    = 6,
    parameter int MAX_SHIFT = 3,
    localparam int SC_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              base_en,
    input  logic [AW-1:0]     base_val,
    input  logic              idx_en,
    input  logic [RSEL_W-1:0] idx_sel,
    input  logic [AW-1:0]     idx_val,
    input  logic [SC_W-1:0]   scale_code,
    input  logic [AW-1:0]     disp_raw,
    input  logic [1:0]        disp_size,
    input  logic              src_mem,
    input  logic              dst_mem,
    output logic              ea_valid,
    output logic [AW-1:0]     ea_addr,
    output logic              ea_fault
);
    ea_state_t st_d, st_q;

    logic [AW-1:0] disp_term;
    logic [AW-1:0] idx_term;
    logic [AW-1:0] base_term;
    logic          sp_as_idx;
    logic          mem_to_mem;

    ea_disp_ext #(.AW(AW)) u_disp (
        .raw  (disp_raw),
        .size (disp_size),
        .ext  (disp_term)
    );

    ea_idx_scaler #(.AW(AW), .MAX_SHIFT(MAX_SHIFT)) u_scale (
        .en     (idx_en),
        .code   (scale_code),
        .val    (idx_val),
        .scaled (idx_term)
    );

    assign base_term  = base_en ? base_val : '0;
    assign sp_as_idx  = idx_en && (idx_sel == RSEL_W'(SP_NUM));
    assign mem_to_mem = src_mem && dst_mem;

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        st_d.flt = 1'b0;
        if (req_valid) begin
            st_d.flt  = sp_as_idx || mem_to_mem;
            st_d.addr = base_term + idx_term + disp_term;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ea_valid = st_q.vld;
    assign ea_addr  = st_q.addr;
    assign ea_fault = st_q.flt;

    AST_SP_INDEX_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idx_en && idx_sel == RSEL_W'(SP_NUM)) |=> ea_fault); // R6
    AST_MEM_MEM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && src_mem && dst_mem) |=> ea_fault); // R7
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ea_valid); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!ea_valid && !ea_fault && $stable(ea_addr))); // R8
    AST_NO_TERMS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !base_en && !idx_en && disp_size == 2'd0) |=> (ea_addr == '0)); // R4
endmodule

// File: tb/scaled_ea_unit_tb.sv
module scaled_ea_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, base_en = 1'b0, idx_en = 1'b0;
    logic [31:0] base_val = '0, idx_val = '0, disp_raw = '0;
    logic [2:0]  idx_sel = '0;
    logic [1:0]  scale_code = '0, disp_size = '0;
    logic        src_mem = 1'b0, dst_mem = 1'b0;
    logic        ea_valid, ea_fault;
    logic [31:0] ea_addr;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    logic        x_vld = 1'b0, x_flt = 1'b0, x_chk_addr = 1'b1;
    logic [31:0] x_addr = '0;
    string       x_tag = "R9";

    always #10 clk = ~clk;

    scaled_ea_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .base_en(base_en), .base_val(base_val),
        .idx_en(idx_en), .idx_sel(idx_sel), .idx_val(idx_val),
        .scale_code(scale_code), .disp_raw(disp_raw), .disp_size(disp_size),
        .src_mem(src_mem), .dst_mem(dst_mem),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_fault(ea_fault)
    );

    task automatic compare();
        n_vec++;
        if (ea_valid !== x_vld) begin
            n_bad++;
            $display("FAIL %s valid: got %0b exp %0b", x_tag, ea_valid, x_vld);
        end
        if (ea_fault !== x_flt) begin
            n_bad++;
            $display("FAIL %s fault: got %0b exp %0b", x_tag, ea_fault, x_flt);
        end
        if (x_chk_addr && ea_addr !== x_addr) begin
            n_bad++;
            $display("FAIL %s addr: got %h exp %h", x_tag, ea_addr, x_addr);
        end
    endtask

    task automatic req(input string tag, input bit be, input logic [31:0] bv,
                       input bit ie, input logic [2:0] isel, input logic [31:0] iv,
                       input logic [1:0] sc, input logic [31:0] dr, input logic [1:0] dsz,
                       input bit sm, input bit dm);
        longint unsigned sum;
        logic [31:0] dterm;
        @(negedge clk);
        compare();
        req_valid = 1'b1; base_en = be; base_val = bv; idx_en = ie; idx_sel = isel;
        idx_val = iv; scale_code = sc; disp_raw = dr; disp_size = dsz;
        src_mem = sm; dst_mem = dm;
        case (dsz)
            2'd0:    dterm = 32'd0;
            2'd1:    dterm = 32'(int'($signed(dr[7:0])));
            2'd2:    dterm = 32'(int'($signed(dr[15:0])));
            default: dterm = dr;
        endcase
        sum = (be ? longint'(bv) : 0) + (ie ? longint'(iv) * (longint'(1) << sc) : 0) + longint'(dterm);
        x_vld = 1'b1;
        x_flt = (ie && isel == 3'd6) || (sm && dm);
        x_chk_addr = !x_flt;
        x_addr = sum[31:0];
        x_tag = tag;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        compare();
        req_valid = 1'b0;
        base_val = 32'hA5A5_A5A5; idx_val = 32'h5A5A_5A5A;
        x_vld = 1'b0; x_flt = 1'b0; x_chk_addr = 1'b1;
        x_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare();                  // R9 during reset
        rst_n = 1'b1;
        idle("R9");
        idle("R9");
        // R1 full form: 0x1000 + 0x10*4 + 0x20
        req("R1", 1, 32'h1000, 1, 3'd1, 32'h10, 2'd2, 32'h20, 2'd3, 0, 0);
        // R2 each scale code
        req("R2", 0, 0, 1, 3'd2, 32'd3, 2'd0, 0, 2'd0, 0, 0);
        req("R2", 0, 0, 1, 3'd2, 32'd3, 2'd1, 0, 2'd0, 0, 0);
        req("R2", 0, 0, 1, 3'd2, 32'd3, 2'd2, 0, 2'd0, 0, 0);
        req("R2", 0, 0, 1, 3'd2, 32'd3, 2'd3, 0, 2'd0, 0, 0);
        // R3 displacement widths
        req("R3", 1, 32'h100, 0, 0, 0, 0, 32'h0000_0080, 2'd1, 0, 0);
        req("R3", 1, 32'h100, 0, 0, 0, 0, 32'h1234_567F, 2'd1, 0, 0);
        req("R3", 0, 0, 0, 0, 0, 0, 32'h0000_8000, 2'd2, 0, 0);
        req("R3", 0, 0, 0, 0, 0, 0, 32'h8000_0000, 2'd3, 0, 0);
        req("R3", 1, 32'h40, 0, 0, 0, 0, 32'hFFFF_FFFF, 2'd0, 0, 0);
        // R4 index absent
        req("R4", 1, 32'h50, 0, 3'd1, 32'hFFFF, 2'd3, 0, 2'd0, 0, 0);
        req("R4", 0, 32'h77, 0, 3'd1, 32'h1, 2'd1, 0, 2'd0, 0, 0);
        // R5 base absent
        req("R5", 0, 32'hDEAD_BEEF, 1, 3'd3, 32'h20, 2'd1, 32'h4, 2'd1, 0, 0);
        // R6 stack pointer as index; other indexes legal
        req("R6", 1, 32'h10, 1, 3'd6, 32'h4, 2'd0, 0, 2'd0, 0, 0);
        req("R6", 1, 32'h10, 1, 3'd7, 32'h4, 2'd0, 0, 2'd0, 0, 0);
        req("R6", 1, 32'h10, 0, 3'd6, 32'h4, 2'd0, 0, 2'd0, 0, 0);
        // R7 memory to memory
        req("R7", 1, 32'h200, 0, 0, 0, 0, 0, 2'd0, 1, 1);
        req("R7", 1, 32'h200, 0, 0, 0, 0, 0, 2'd0, 1, 0);
        req("R7", 1, 32'h200, 0, 0, 0, 0, 0, 2'd0, 0, 1);
        // R8 idle hold after a known address
        req("R8", 1, 32'h1234, 0, 0, 0, 0, 0, 2'd0, 0, 0);
        idle("R8");
        idle("R8");
        // R10 wraparound
        req("R10", 1, 32'hFFFF_FFF0, 0, 0, 0, 0, 32'h20, 2'd3, 0, 0);
        req("R10", 1, 32'hF000_0000, 1, 3'd0, 32'h2000_0000, 2'd3, 32'hFFFF_FFFF, 2'd1, 0, 0);
        idle("R8");
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule